// File: doc/BRIEF.md
# Random Multicarrier Triangle Selector

This block produces a digital triangular carrier whose frequency hops at random among four fixed rates. Four up/down counters run side by side. Each one uses its own clock prescaler, so the four triangles repeat at 1, 2, 3 and 4 kHz of a common system clock. All four share one normalized peak value. Two free-running linear feedback shift registers, one 16 stages long and one 8 stages long, each contribute one pseudo-random bit. Together the two bits name the carrier that drives the output.

A new carrier is chosen only at a valley, when the carrier in use has finished a whole period. At that point the newly chosen generator is restarted from zero, so the output waveform never shows a truncated slope or a jump. Each hop raises a one-cycle strobe and reports the length of the new period in clock cycles. Downstream timing logic uses this to schedule its sampling. The selected sample is meant to be compared against a modulating reference further down the chain.

The control is a two-state machine. `ST_LAUNCH` is entered from reset and lasts one cycle. In it the first carrier is chosen (transition *launch → run*). `ST_RUN` stays in itself. On the *valley hop* transition, which happens when the active generator completes a period, it re-picks a carrier.

Top module: `rmc_carrier_select`

## Requirements
- R1: The 16-stage register holds stages B1..B16. Each clock it shifts B(k) into B(k+1) and loads B1 with B16^B14^B13^B11. That feedback bit is driven on `prbs16_bit_o`. Reset loads seed `SEED16`, and the register is never left all-zero.
- R2: The 8-stage register behaves the same way with feedback B8^B6^B5^B4 into B1, output `prbs8_bit_o`, and seed `SEED8`.
- R3: At each hop the bit pair {16-stage bit, 8-stage bit} sampled at that clock edge selects the carrier as follows: 00 gives the 2 kHz carrier, 01 gives 3 kHz, 10 gives 4 kHz and 11 gives 1 kHz.
- R4: The selection changes only at a valley. Between two consecutive cycles the output moves by at most one step and never jumps.
- R5: A period starts at 0. The sample rises by one every DIV clocks of the chosen carrier up to `PEAK`, then falls back by one every DIV clocks. It never exceeds `PEAK`.
- R6: `period_stb_o` is high for exactly one cycle: the first cycle after reset release, and the cycle in which a new period starts at sample 0. Periods last 2·PEAK·DIV cycles.
- R7: `period_len_o` shows 2·PEAK·DIV of the newly chosen carrier from the strobe cycle onward and holds that value until the next strobe.
- R8: While reset is held, the sample is 0, the strobe is low, `period_len_o` is 0, and the PRBS outputs show the feedback bits of the seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| carrier_o | output | CW | Selected triangle sample, 0..PEAK |
| prbs16_bit_o | output | 1 | Feedback bit of the 16-stage generator |
| prbs8_bit_o | output | 1 | Feedback bit of the 8-stage generator |
| period_stb_o | output | 1 | One-cycle strobe at each period start |
| period_len_o | output | LEN_W | Length in clocks of the period just started |

## Verification
The bench runs a reduced configuration with peak 4 and prescalers 12/6/4/3, so every hop produces a distinct period length. It tracks both shift registers and the triangle arithmetic cycle by cycle.

The bench targets three kinds of error:
- **Hop timing.** A design that re-picks one cycle early or late, or picks on the wrong carrier's valley, shows a strobe off the expected cycle and a sample that jumps.
- **Bit-pair mapping.** A swapped or rotated mapping shows a wrong period length for the recorded bit pair.
- **Shift register structure.** A wrong tap or shift direction shows on the reported bits within a few cycles.

A reset in the middle of the run checks that the launch sequence restarts from the seeds.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
    localparam int unsigned NUM_CAR = 4;

    typedef enum logic [1:0] {
        CAR_1K = 2'd0,
        CAR_2K = 2'd1,
        CAR_3K = 2'd2,
        CAR_4K = 2'd3
    } car_idx_t;

    typedef enum logic {
        ST_LAUNCH = 1'b0,
        ST_RUN    = 1'b1
    } sel_state_t;
endpackage

// File: rtl/rmc_prbs.sv
module rmc_prbs #(
    parameter int unsigned     W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400,
    parameter logic [W-1:0]    SEED = 16'hACE1
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic bit_o
);
    logic [W-1:0] shreg_q;
    logic         fb;

    // index 0 is the first stage; the feedback enters there
    assign fb    = ^(shreg_q & TAPS);
    assign bit_o = fb;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg_q <= SEED;
        end else if (shreg_q == '0) begin
            shreg_q <= SEED;
        end else begin
            shreg_q <= {shreg_q[W-2:0], fb};
        end
    end
endmodule

// File: rtl/rmc_tri_gen.sv
module rmc_tri_gen #(
    parameter int unsigned PEAK = 125,
    parameter int unsigned DIV  = 500,
    localparam int unsigned VW    = $clog2(PEAK + 1),
    localparam int unsigned PRE_W = $clog2(DIV + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          sync_i,
    output logic [VW-1:0] val_o,
    output logic          wrap_o
);
    logic [PRE_W-1:0] pre_q;
    logic [VW-1:0]    val_q;
    logic             up_q;
    logic             tick;

    assign tick   = (pre_q == PRE_W'(DIV - 1));
    assign wrap_o = tick && !up_q && (val_q == VW'(1));
    assign val_o  = val_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || sync_i) begin
            pre_q <= '0;
            val_q <= '0;
            up_q  <= 1'b1;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                if (up_q) begin
                    val_q <= val_q + 1'b1;
                    if (val_q + 1'b1 == VW'(PEAK)) up_q <= 1'b0;
                end else begin
                    val_q <= val_q - 1'b1;
                    if (val_q == VW'(1)) up_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rmc_carrier_select.sv
module rmc_carrier_select
    import rmc_pkg::*;
#(
    parameter int unsigned  PEAK   = 125,
    parameter int unsigned  DIV_1K = 500,
    parameter int unsigned  DIV_2K = 250,
    parameter int unsigned  DIV_3K = 167,
    parameter int unsigned  DIV_4K = 125,
    parameter logic [15:0]  SEED16 = 16'hACE1,
    parameter logic [7:0]   SEED8  = 8'h5B,
    localparam int unsigned CW      = $clog2(PEAK + 1),
    localparam int unsigned MAX_DIV = (DIV_1K > DIV_2K ? DIV_1K : DIV_2K) > (DIV_3K > DIV_4K ? DIV_3K : DIV_4K)
                                    ? (DIV_1K > DIV_2K ? DIV_1K : DIV_2K) : (DIV_3K > DIV_4K ? DIV_3K : DIV_4K),
    localparam int unsigned LEN_W   = $clog2(2 * PEAK * MAX_DIV + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CW-1:0]    carrier_o,
    output logic             prbs16_bit_o,
    output logic             prbs8_bit_o,
    output logic             period_stb_o,
    output logic [LEN_W-1:0] period_len_o
);
    localparam int unsigned DIV_TAB [NUM_CAR] = '{DIV_1K, DIV_2K, DIV_3K, DIV_4K};

    sel_state_t           state_q, state_d;
    car_idx_t             sel_q, sel_d, pick;
    logic                 stb_q, boundary;
    logic [LEN_W-1:0]     len_q, len_d;
    logic [CW-1:0]        val_w [NUM_CAR];
    logic [NUM_CAR-1:0]   wrap_w, sync_w;

    function automatic logic [LEN_W-1:0] len_of(car_idx_t c);
        return LEN_W'(2 * PEAK * DIV_TAB[int'(c)]);
    endfunction

    rmc_prbs #(.W(16), .TAPS(16'hB400), .SEED(SEED16)) u_prbs16 (
        .clk_i(clk_i), .rst_i(rst_i), .bit_o(prbs16_bit_o)
    );
    rmc_prbs #(.W(8), .TAPS(8'hB8), .SEED(SEED8)) u_prbs8 (
        .clk_i(clk_i), .rst_i(rst_i), .bit_o(prbs8_bit_o)
    );

    for (genvar g = 0; g < NUM_CAR; g++) begin : g_car
        rmc_tri_gen #(.PEAK(PEAK), .DIV(DIV_TAB[g])) u_tri (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .sync_i(sync_w[g]),
            .val_o (val_w[g]),
            .wrap_o(wrap_w[g])
        );
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_LAUNCH;
        else       state_q <= state_d;
    end

    // next state and hop decision
    always_comb begin
        state_d  = state_q;
        boundary = 1'b0;
        unique case (state_q)
            ST_LAUNCH: begin
                state_d  = ST_RUN;
                boundary = 1'b1;
            end
            ST_RUN: begin
                boundary = wrap_w[sel_q];
            end
            default: ;
        endcase
        pick   = car_idx_t'(2'({prbs16_bit_o, prbs8_bit_o}) + 2'd1);
        sel_d  = boundary ? pick : sel_q;
        len_d  = boundary ? len_of(pick) : len_q;
        sync_w = boundary ? (NUM_CAR'(1) << pick) : '0;
    end

    // output registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q <= CAR_1K;
            stb_q <= 1'b0;
            len_q <= '0;
        end else begin
            sel_q <= sel_d;
            stb_q <= boundary;
            len_q <= len_d;
        end
    end

    assign carrier_o    = val_w[sel_q];
    assign period_stb_o = stb_q;
    assign period_len_o = len_q;
endmodule

// File: rtl/rmc_carrier_select_chk.sv
module rmc_carrier_select_chk #(
    parameter int unsigned PEAK   = 125,
    parameter int unsigned DIV_1K = 500,
    parameter int unsigned DIV_2K = 250,
    parameter int unsigned DIV_3K = 167,
    parameter int unsigned DIV_4K = 125,
    parameter int unsigned CW     = 7,
    parameter int unsigned LEN_W  = 17
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [CW-1:0]    carrier_o,
    input logic             prbs16_bit_o,
    input logic             prbs8_bit_o,
    input logic             period_stb_o,
    input logic [LEN_W-1:0] period_len_o
);
    function automatic logic [LEN_W-1:0] len_for_bits(logic [1:0] b);
        unique case (b)
            2'b00:   return LEN_W'(2 * PEAK * DIV_2K);
            2'b01:   return LEN_W'(2 * PEAK * DIV_3K);
            2'b10:   return LEN_W'(2 * PEAK * DIV_4K);
            default: return LEN_W'(2 * PEAK * DIV_1K);
        endcase
    endfunction

    AST_SEL_FROM_BITS: assert property (@(posedge clk_i) disable iff (rst_i)
        period_stb_o |-> period_len_o == len_for_bits($past({prbs16_bit_o, prbs8_bit_o}))) else $error("sel"); // R3
    AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ({1'b0, carrier_o} == {1'b0, $past(carrier_o)}
               || {1'b0, carrier_o} == {1'b0, $past(carrier_o)} + (CW+1)'(1)
               || {1'b0, carrier_o} + (CW+1)'(1) == {1'b0, $past(carrier_o)})) else $error("step"); // R4
    AST_PEAK_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
        carrier_o <= CW'(PEAK)) else $error("peak"); // R5
    AST_VALLEY_AT_STB: assert property (@(posedge clk_i) disable iff (rst_i)
        period_stb_o |-> carrier_o == '0) else $error("valley"); // R6
    AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        period_stb_o |=> !period_stb_o) else $error("single"); // R6
    AST_LEN_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !period_stb_o |-> $stable(period_len_o)) else $error("hold"); // R7
endmodule

bind rmc_carrier_select rmc_carrier_select_chk #(
    .PEAK(PEAK), .DIV_1K(DIV_1K), .DIV_2K(DIV_2K), .DIV_3K(DIV_3K), .DIV_4K(DIV_4K),
    .CW(CW), .LEN_W(LEN_W)
) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .carrier_o(carrier_o),
    .prbs16_bit_o(prbs16_bit_o), .prbs8_bit_o(prbs8_bit_o),
    .period_stb_o(period_stb_o), .period_len_o(period_len_o)
);

// File: tb/rmc_carrier_select_tb_top.sv
`timescale 1ns/1ps
module rmc_carrier_select_tb_top;
    localparam int unsigned PK = 4;
    localparam logic [15:0] S16 = 16'hACE1;
    localparam logic [7:0]  S8  = 8'h5B;
    localparam int unsigned CWB = $clog2(PK + 1);
    localparam int unsigned LWB = $clog2(2 * PK * 12 + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CWB-1:0] carrier;
    logic b16, b8, stb;
    logic [LWB-1:0] plen;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rmc_carrier_select #(.PEAK(PK), .DIV_1K(12), .DIV_2K(6), .DIV_3K(4), .DIV_4K(3),
                         .SEED16(S16), .SEED8(S8)) dut_i (
        .clk_i(clk), .rst_i(rst), .carrier_o(carrier), .prbs16_bit_o(b16),
        .prbs8_bit_o(b8), .period_stb_o(stb), .period_len_o(plen)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic f16(logic [15:0] s);
        return s[15] ^ s[13] ^ s[12] ^ s[10];
    endfunction
    function automatic logic f8(logic [7:0] s);
        return s[7] ^ s[5] ^ s[4] ^ s[3];
    endfunction

    int unsigned div_tab [4] = '{12, 6, 4, 3};
    logic [15:0] m16;
    logic [7:0]  m8;
    bit  launch_pend = 1'b1;
    int  t = 0, cur_len = 0, cur_div = 1;
    int  seen [4] = '{0, 0, 0, 0};

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                m16 = S16; m8 = S8; launch_pend = 1'b1; t = 0;
                chk(stb == 1'b0, "R8", int'(stb), 0);
                chk(carrier == '0, "R8", int'(carrier), 0);
                chk(plen == '0, "R8", int'(plen), 0);
                chk(b16 == f16(S16) && b8 == f8(S8), "R8", int'({b16, b8}), int'({f16(S16), f8(S8)}));
            end else begin
                logic pb16, pb8, exp_stb;
                int idx, p, ev;
                pb16 = f16(m16); pb8 = f8(m8);
                m16 = {m16[14:0], pb16};
                m8  = {m8[6:0], pb8};
                chk(b16 == f16(m16), "R1", int'(b16), int'(f16(m16)));
                chk(b8 == f8(m8), "R2", int'(b8), int'(f8(m8)));
                exp_stb = launch_pend || (t + 1 == cur_len);
                chk(stb == exp_stb, "R6", int'(stb), int'(exp_stb));
                if (exp_stb) begin
                    idx = (int'({pb16, pb8}) + 1) % 4;
                    cur_div = int'(div_tab[idx]);
                    cur_len = 2 * PK * cur_div;
                    seen[idx]++;
                    t = 0;
                    launch_pend = 1'b0;
                    chk(int'(plen) == cur_len, "R3", int'(plen), cur_len);
                end else begin
                    t++;
                    chk(int'(plen) == cur_len, "R7", int'(plen), cur_len);
                end
                p  = t / cur_div;
                ev = (p <= PK) ? p : 2 * PK - p;
                chk(int'(carrier) == ev, "R5 shape, R4 continuity", int'(carrier), ev);
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        #1 rst = 1'b0;
        repeat (8000) @(negedge clk);
        #1 rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        repeat (4000) @(negedge clk);
        for (int i = 0; i < 4; i++) chk(seen[i] > 0, "R3 mapping coverage", seen[i], 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule